// File: doc/BRIEF.md
# DDR Mode Register Programming Unit

This block holds the mode register of a DDR memory device as it is seen from the command side. A mode-register-set strobe arrives with two bank-select bits and a 13-bit address word. When the bank bits are both zero, the word is taken as a new register value. The unit checks three things before it accepts the word: the device is free to be reprogrammed, the wait window after the previous write has ended, and every field carries a supported code. If all three hold, it stores the burst length, the burst ordering and the read latency.

The operating-mode bits are decoded on every accepted write. A request for a DLL reset produces a single-cycle pulse, and it is not kept afterwards, so the stored mode always reads as normal operation. A write that is refused leaves the stored configuration exactly as it was. Such a write raises one of two single-cycle error flags. One flag marks a word that carries a reserved code. The other marks a command issued at a moment when programming is not allowed.

Top module: `ddr_mode_reg`

## Requirements
- R1: A command whose bank-select bits are anything other than 00 changes no output: the configuration stays the same, no error flag rises, no DLL pulse appears and busy does not assert.
- R2: For an accepted write, address bits [2:0] give the burst length: code 001 means 2, 010 means 4 and 011 means 8. Address bit 3 gives the ordering: 0 is sequential and 1 is interleaved. Both outputs update one cycle after the command edge.
- R3: For an accepted write, address bits [6:4] give the read latency: code 010 means 2 clocks (lat_half=0) and code 110 means 2.5 clocks (lat_half=1).
- R4: When address bits [12:7] equal 000010, an accepted write makes dll_reset high for exactly one cycle, one cycle after the command edge. When those bits are all zero, no pulse appears.
- R5: A write made at an allowed moment with a reserved code in any field raises cfg_err for one cycle. The reserved codes are: burst codes other than 001, 010 and 011; latency codes other than 010 and 110; and mode bits other than 000000 and 000010. Such a write leaves every stored field unchanged and does not start the wait window.
- R6: After an accepted write, busy is high for BUSY_CYCLES cycles (2 by default), beginning one cycle after the command edge.
- R7: A command to this register issued while busy is high or while banks_idle is low raises seq_err for one cycle. The command is ignored, and it raises no cfg_err even if its word is also reserved.
- R8: After reset, the outputs show a burst length of 2, sequential ordering and a latency of 2 clocks, with busy, dll_reset, cfg_err and seq_err all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_cmd | input | 1 | Mode-register-set command strobe |
| ba | input | 2 | Bank-select bits qualifying the command |
| addr | input | 13 | Register word carried by the command |
| banks_idle | input | 1 | High when all banks are idle and no burst is running |
| burst_len | output | 4 | Stored burst length (2, 4 or 8) |
| burst_interleave | output | 1 | Stored ordering, 1 = interleaved |
| lat_half | output | 1 | Stored latency, 0 = 2 clocks, 1 = 2.5 clocks |
| busy | output | 1 | Wait window after an accepted write |
| dll_reset | output | 1 | One-cycle DLL reset pulse |
| cfg_err | output | 1 | One-cycle flag for a reserved code |
| seq_err | output | 1 | One-cycle flag for a command at a forbidden moment |

## Verification
The hardest case to reach from the ports is a command that arrives inside the wait window left by the write just before it. The command must land on the edge directly after an accepted write. To get there, the stimulus holds the strobe high across two consecutive edges with a different word on the second edge. The bench then checks that the second word raises seq_err and leaves the first word's configuration in place. A second case sends a word that is both reserved and issued while banks_idle is low, to confirm which of the two error flags wins.

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg #(
  parameter int BUSY_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mrs_cmd,
  input  logic [1:0]  ba,
  input  logic [12:0] addr,
  input  logic        banks_idle,
  output logic [3:0]  burst_len,
  output logic        burst_interleave,
  output logic        lat_half,
  output logic        busy,
  output logic        dll_reset,
  output logic        cfg_err,
  output logic        seq_err
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [2:0]    bl_q;
  logic          bt_q;
  logic [2:0]    cl_q;
  logic [CW-1:0] wait_cnt;

  wire hit       = mrs_cmd && (ba == 2'b00);
  wire blocked   = busy || !banks_idle;
  wire bl_ok     = (addr[2:0] == 3'b001) || (addr[2:0] == 3'b010) || (addr[2:0] == 3'b011);
  wire cl_ok     = (addr[6:4] == 3'b010) || (addr[6:4] == 3'b110);
  wire mode_norm = (addr[12:7] == 6'b000000);
  wire mode_dll  = (addr[12:7] == 6'b000010);
  wire fields_ok = bl_ok && cl_ok && (mode_norm || mode_dll);
  wire wr_ok     = hit && !blocked && fields_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_q      <= 3'b001;
      bt_q      <= 1'b0;
      cl_q      <= 3'b010;
      wait_cnt  <= '0;
      dll_reset <= 1'b0;
      cfg_err   <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      dll_reset <= wr_ok && mode_dll;
      cfg_err   <= hit && !blocked && !fields_ok;
      seq_err   <= hit && blocked;
      if (wr_ok) begin
        bl_q     <= addr[2:0];
        bt_q     <= addr[3];
        cl_q     <= addr[6:4];
        wait_cnt <= CW'(BUSY_CYCLES);
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - CW'(1);
      end
    end
  end

  assign burst_len        = 4'd1 << bl_q;
  assign burst_interleave = bt_q;
  assign lat_half         = cl_q[2];
  assign busy             = (wait_cnt != '0);

  AST_RSV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($stable(burst_len) && $stable(burst_interleave) && $stable(lat_half))); // R5
  AST_VIOL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> ($stable(burst_len) && $stable(burst_interleave) && $stable(lat_half))); // R7
  AST_DLL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset |=> !dll_reset); // R4
  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> busy); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && busy) |=> (seq_err && !cfg_err && !dll_reset)); // R7
  AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_cmd && ba != 2'b00 && !busy) |=> (!cfg_err && !seq_err && !dll_reset && !busy)); // R1
  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burst_len) && burst_len != 4'd1 && burst_len != 4'd0); // R2
endmodule

// File: tb/ddr_mode_reg_tb.sv
module ddr_mode_reg_tb;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n, mrs_cmd, banks_idle;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [3:0] burst_len;
  logic burst_interleave, lat_half, busy, dll_reset, cfg_err, seq_err;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ddr_mode_reg u_dut (
    .clk(clk), .rst_n(rst_n), .mrs_cmd(mrs_cmd), .ba(ba), .addr(addr),
    .banks_idle(banks_idle), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .lat_half(lat_half), .busy(busy),
    .dll_reset(dll_reset), .cfg_err(cfg_err), .seq_err(seq_err)
  );

  // {ba, mode[5:0], cl[2:0], bt, bl[2:0], idle, exp_len[3:0], exp_il, exp_half, exp_dll, exp_rsv, exp_viol}
  localparam logic [24:0] VEC [NV] = '{
    {2'b00, 6'b000000, 3'b010, 1'b0, 3'b001, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b00, 6'b000000, 3'b110, 1'b1, 3'b010, 1'b1, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b00, 6'b000010, 3'b010, 1'b0, 3'b011, 1'b1, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b00, 6'b000000, 3'b010, 1'b1, 3'b000, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b00, 6'b000000, 3'b110, 1'b1, 3'b111, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b00, 6'b000000, 3'b011, 1'b1, 3'b010, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b00, 6'b000001, 3'b110, 1'b1, 3'b010, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b00, 6'b000110, 3'b110, 1'b1, 3'b010, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b01, 6'b000000, 3'b110, 1'b1, 3'b010, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b10, 6'b000010, 3'b110, 1'b1, 3'b010, 1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b00, 6'b000000, 3'b110, 1'b1, 3'b010, 1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'b00, 6'b000010, 3'b110, 1'b1, 3'b010, 1'b1, 4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mrs_cmd = 1'b0; ba = 2'b00; addr = '0; banks_idle = 1'b1;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 len", burst_len, 2);
    chk("R8 il", burst_interleave, 0);
    chk("R8 half", lat_half, 0);
    chk("R8 flags", {busy, dll_reset, cfg_err, seq_err}, 0);

    for (int v = 0; v < NV; v++) begin
      ba = VEC[v][24:23]; addr = VEC[v][22:10]; banks_idle = VEC[v][9];
      mrs_cmd = 1'b1;
      @(negedge clk);
      mrs_cmd = 1'b0; banks_idle = 1'b1;
      chk("R2 len", burst_len, int'(VEC[v][8:5]));
      chk("R2 il", burst_interleave, int'(VEC[v][4]));
      chk("R3 half", lat_half, int'(VEC[v][3]));
      chk("R4 dll", dll_reset, int'(VEC[v][2]));
      chk("R5 cfg_err", cfg_err, int'(VEC[v][1]));
      chk("R7 seq_err", seq_err, int'(VEC[v][0]));
      if (VEC[v][24:23] != 2'b00) chk("R1 busy", busy, 0);
      if (VEC[v][1]) chk("R5 busy", busy, 0);
      idle_cycles(3);
    end

    // R6 / R7: second command on the edge right after an accepted write
    ba = 2'b00; addr = {6'b000010, 3'b010, 1'b0, 3'b001}; mrs_cmd = 1'b1;
    @(negedge clk);
    chk("R6 busy1", busy, 1);
    chk("R4 dll first", dll_reset, 1);
    addr = {6'b000000, 3'b110, 1'b1, 3'b011};
    @(negedge clk);
    mrs_cmd = 1'b0;
    chk("R4 dll gone", dll_reset, 0);
    chk("R7 seq_err busy", seq_err, 1);
    chk("R7 len kept", burst_len, 2);
    chk("R7 half kept", lat_half, 0);
    chk("R6 busy2", busy, 1);
    @(negedge clk);
    chk("R6 busy end", busy, 0);
    chk("R7 seq_err pulse", seq_err, 0);

    // R7: reserved word while banks not idle gives only seq_err
    addr = {6'b000000, 3'b111, 1'b0, 3'b000}; banks_idle = 1'b0; mrs_cmd = 1'b1;
    @(negedge clk);
    mrs_cmd = 1'b0; banks_idle = 1'b1;
    chk("R7 seq_err both", seq_err, 1);
    chk("R7 no cfg_err", cfg_err, 0);
    idle_cycles(2);

    // R8: reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 len again", burst_len, 2);
    chk("R8 il again", burst_interleave, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule